// File: doc/BRIEF.md
# Two-Channel Center/Edge-Aligned PWM Generator

This block produces two pulse-width-modulated channels, each made of a high-side output and a complementary low-side output. A single counter running on the peripheral clock sets the switching period for both channels. Each channel compares the counter against its own signed duty value. In edge-aligned mode the counter ramps up once per period, so each high-side pulse starts at the period boundary. In center-aligned mode the counter ramps down and then up again, so the period is twice the programmed value and each pulse sits symmetrically about the period midpoint.

Software writes settings through a small write port. Period, duty and mode writes land in shadow registers. The active copies are refreshed only on the first clock of a new switching period, so a period never mixes old and new settings. A one-clock sync pulse marks every period start. A period value below 2 is not a legal setting: the block then keeps all outputs low and raises no sync. It recovers on its own as soon as a legal period is written.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset and whenever the enable bit (bit 0 of the control word) is clear, all high-side outputs, all low-side outputs and the sync output are low.
- R2: With control bit 1 clear (edge-aligned), a switching period lasts exactly P clocks, where P is the period value. The high-side output is on for the first D clocks of the period, where D is the duty value.
- R3: With control bit 1 set (center-aligned), a switching period lasts exactly 2·P clocks. The high-side output is on for 2·D clocks, starting at clock P−D of the period, so the pulse is symmetric about the midpoint.
- R4: While enabled with a period value of 0 or 1, all outputs stay low and no sync pulse appears. Writing a legal period afterwards restarts normal operation without a disable.
- R5: A negative duty value (bit 15 set) gives 0 % high-side on-time. A duty value at or above P gives 100 % on-time, in both modes.
- R6: While a legal period is running, each low-side output is the inverse of its high-side output on every clock.
- R7: The sync output is high for exactly one clock, on the first clock of every switching period.
- R8: Period and duty writes made during a period do not change that period. They take effect from the next period start.
- R9: The write address selects the target: 0 is the control word, 1 is the period, 2 is the duty of channel A (output index 0) and 3 is the duty of channel B (output index 1).
- R10: In center-aligned mode a period value of 10000 gives a 20000-clock period. With a 200 MHz clock this is a 10 kHz switching frequency.
- R11: Clearing the enable bit drives the outputs low from the clock after the write. Setting it again starts a fresh period whose sync pulse appears one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; all counting runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 2 | Target select: 0 control, 1 period, 2 duty A, 3 duty B |
| wr_data | input | 16 | Write data; for control, bit 0 enables and bit 1 selects center-aligned mode |
| pwm_hi | output | 2 | High-side outputs; index 0 is channel A, index 1 is channel B |
| pwm_lo | output | 2 | Low-side outputs, the inverse of the high side while running |
| sync_o | output | 1 | One-clock pulse at the start of each switching period |

## Verification
The hardest situation to produce from the ports is a write that lands in the middle of a running period. The test has to show that the current period still finishes with its old length and duty, and that the new values take over exactly at the next boundary. The bench reaches this state by waiting for a sync pulse. It then runs a period measurement in parallel with a burst of period and duty writes, and measures the following period separately. Recovery from an illegal period is reached the same way: the bench enables the block with the illegal period, watches the outputs stay quiet, and then writes a legal period without ever disabling the block.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   typedef enum logic {
      MODE_EDGE   = 1'b0,
      MODE_CENTER = 1'b1
   } pwm_mode_e;

   localparam int unsigned ADDR_CTRL     = 0;
   localparam int unsigned ADDR_PERIOD   = 1;
   localparam int unsigned ADDR_DUTY0    = 2;
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_MODE_BIT = 1;
   localparam int unsigned MIN_PERIOD    = 2;
endpackage

// File: rtl/dpwm_shadow.sv
module dpwm_shadow
   import dpwm_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   output logic                          en_q,
   output pwm_mode_e                     sh_mode,
   output logic [CNT_W-1:0]              sh_per,
   output logic [NCH-1:0][CNT_W-1:0]     sh_duty
);
   logic hit_ctrl;
   logic hit_per;

   assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
   assign hit_per  = wr_en && (wr_addr == ADDR_W'(ADDR_PERIOD));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         sh_mode <= MODE_EDGE;
      end else if (hit_ctrl) begin
         en_q    <= wr_data[CTRL_EN_BIT];
         sh_mode <= pwm_mode_e'(wr_data[CTRL_MODE_BIT]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_per <= '0;
      end else if (hit_per) begin
         sh_per <= wr_data;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_duty
      logic hit_duty;
      assign hit_duty = wr_en && (wr_addr == ADDR_W'(ADDR_DUTY0 + i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_duty[i] <= '0;
         end else if (hit_duty) begin
            sh_duty[i] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
   import dpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_q,
   input  pwm_mode_e        sh_mode,
   input  logic [CNT_W-1:0] sh_per,
   output logic             load,
   output logic             running,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] act_per,
   output logic             first_q
);
   logic      down_q;
   pwm_mode_e act_mode;
   logic      period_end;
   logic      sh_legal;

   // a period closes on the last tick of the up-ramp in either mode
   assign period_end = !down_q && (cnt == act_per - 1'b1);
   assign load       = en_q && (!running || period_end);
   assign sh_legal   = (sh_per >= CNT_W'(MIN_PERIOD));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running  <= 1'b0;
         cnt      <= '0;
         down_q   <= 1'b0;
         first_q  <= 1'b0;
         act_per  <= '0;
         act_mode <= MODE_EDGE;
      end else if (!en_q) begin
         running <= 1'b0;
         cnt     <= '0;
         down_q  <= 1'b0;
         first_q <= 1'b0;
      end else if (load) begin
         act_per  <= sh_per;
         act_mode <= sh_mode;
         running  <= sh_legal;
         first_q  <= 1'b1;
         if (sh_mode == MODE_CENTER) begin
            cnt    <= sh_per - 1'b1;
            down_q <= 1'b1;
         end else begin
            cnt    <= '0;
            down_q <= 1'b0;
         end
      end else begin
         first_q <= 1'b0;
         if (down_q) begin
            if (cnt == '0) begin
               down_q <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // act_mode is kept for the ramp shape of the running period; only the
   // down flag, seeded from it at load, steers the counter afterwards
   logic unused_mode;
   assign unused_mode = (act_mode == MODE_CENTER);
endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] sh_duty,
   output logic             hi,
   output logic             lo
);
   logic [CNT_W-1:0] act_duty;
   logic             on_cmp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_duty <= '0;
      end else if (load) begin
         act_duty <= sh_duty;
      end
   end

   // sign bit set means a negative request: never on
   assign on_cmp = !act_duty[CNT_W-1] && (act_duty > cnt);
   assign hi     = run && on_cmp;
   assign lo     = run && !on_cmp;
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
   import dpwm_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = $clog2(NCH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NCH-1:0]    pwm_hi,
   output logic [NCH-1:0]    pwm_lo,
   output logic              sync_o
);
   localparam int MIN_ADDR_W = $clog2(NCH + 2);

   if (NCH < 1) begin : g_bad_nch
      $error("dual_pwm_gen: NCH must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("dual_pwm_gen: CNT_W must be at least 2");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("dual_pwm_gen: ADDR_W too narrow for NCH duty registers");
   end

   logic                      en_q;
   pwm_mode_e                 sh_mode;
   logic [CNT_W-1:0]          sh_per;
   logic [NCH-1:0][CNT_W-1:0] sh_duty;
   logic                      load;
   logic                      running;
   logic [CNT_W-1:0]          cnt;
   logic [CNT_W-1:0]          act_per;
   logic                      first_q;
   logic                      act_run;

   dpwm_shadow #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .en_q    (en_q),
      .sh_mode (sh_mode),
      .sh_per  (sh_per),
      .sh_duty (sh_duty)
   );

   dpwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_q    (en_q),
      .sh_mode (sh_mode),
      .sh_per  (sh_per),
      .load    (load),
      .running (running),
      .cnt     (cnt),
      .act_per (act_per),
      .first_q (first_q)
   );

   assign act_run = running && en_q;
   assign sync_o  = act_run && first_q;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dpwm_chan #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load),
         .run     (act_run),
         .cnt     (cnt),
         .sh_duty (sh_duty[i]),
         .hi      (pwm_hi[i]),
         .lo      (pwm_lo[i])
      );
   end
endmodule

// File: rtl/dual_pwm_gen_chk.sv
module dual_pwm_gen_chk #(
   parameter int NCH   = 2,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             running,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_per,
   input logic             sync_o,
   input logic [NCH-1:0]   pwm_hi,
   input logic [NCH-1:0]   pwm_lo
);
   AST_OFF_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (pwm_hi == '0 && pwm_lo == '0 && !sync_o)); // R1

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt < act_per)); // R2

   AST_ILLEGAL_PERIOD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && act_per < CNT_W'(2)) |-> (pwm_hi == '0 && pwm_lo == '0 && !sync_o)); // R4

   AST_LOW_IS_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && running) |-> (pwm_lo == ~pwm_hi)); // R6

   AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> !sync_o); // R7

   AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !sync_o && en_q) |-> $stable(act_per)); // R8
endmodule

bind dual_pwm_gen dual_pwm_gen_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_q    (en_q),
   .running (running),
   .cnt     (cnt),
   .act_per (act_per),
   .sync_o  (sync_o),
   .pwm_hi  (pwm_hi),
   .pwm_lo  (pwm_lo)
);

// File: tb/dual_pwm_gen_tb_top.sv
module dual_pwm_gen_tb_top;
   typedef struct packed {
      logic        center;
      logic [15:0] per;
      logic [15:0] da;
      logic [15:0] db;
      int          n;
      int          ha;
      int          hb;
      int          fa;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 16'd10, 16'd3,    16'd7,      10, 3,  7,  0},
      '{1'b1, 16'd10, 16'd3,    16'hFFFF,   20, 6,  0,  7},
      '{1'b0, 16'd8,  16'd8,    16'd0,      8,  8,  0,  0},
      '{1'b1, 16'd5,  16'd100,  16'd4,      10, 10, 8,  0},
      '{1'b0, 16'd2,  16'd1,    16'h8000,   2,  1,  0,  0},
      '{1'b1, 16'd2,  16'd1,    16'd2,      4,  2,  4,  1},
      '{1'b1, 16'd7,  16'd0,    16'd6,      14, 0,  12, -1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  pwm_hi;
   logic [1:0]  pwm_lo;
   logic        sync_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dual_pwm_gen dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_hi  (pwm_hi),
      .pwm_lo  (pwm_lo),
      .sync_o  (sync_o)
   );

   task automatic chk_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_sync(output bit got);
      got = 1'b0;
      for (int i = 0; i < 30000 && !got; i++) begin
         @(negedge clk);
         if (sync_o) got = 1'b1;
      end
   endtask

   // entered at a negedge where sync_o is high; returns at the next one
   task automatic measure(output int n, output int ha, output int hb,
                          output int fa, output int mism);
      n = 0; ha = 0; hb = 0; fa = -1; mism = 0;
      do begin
         if (pwm_hi[0]) begin
            ha++;
            if (fa < 0) fa = n;
         end
         if (pwm_hi[1]) hb++;
         if (pwm_lo != ~pwm_hi) mism++;
         n++;
         @(negedge clk);
      end while (!sync_o && n < 50000);
   endtask

   task automatic quiet_count(input int cycles, output int act);
      act = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (pwm_hi != '0 || pwm_lo != '0 || sync_o) act++;
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int n, ha, hb, fa, mism, q;
      bit got;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk_eq("R1 reset outputs", int'({pwm_hi, pwm_lo, sync_o}), 0);
      rst_n = 1'b1;

      // R1: settings written but enable clear
      wr(2'd1, 16'd10);
      wr(2'd2, 16'd5);
      wr(2'd3, 16'd5);
      quiet_count(30, q);
      chk_eq("R1 disabled quiet", q, 0);

      // table-driven sweep over modes and duty corners (R2, R3, R5, R6, R7, R9)
      for (int v = 0; v < NV; v++) begin
         wr(2'd0, 16'd0);
         wr(2'd1, VEC[v].per);
         wr(2'd2, VEC[v].da);
         wr(2'd3, VEC[v].db);
         wr(2'd0, {14'd0, VEC[v].center, 1'b1});
         wait_sync(got);
         chk_eq("R7 sync seen", int'(got), 1);
         measure(n, ha, hb, fa, mism);
         chk_eq(VEC[v].center ? "R3 period length" : "R2 period length", n, VEC[v].n);
         chk_eq(VEC[v].center ? "R3 A on-time" : "R2 A on-time", ha, VEC[v].ha);
         chk_eq(VEC[v].center ? "R3 A pulse start" : "R2 A pulse start", fa, VEC[v].fa);
         chk_eq("R5 R9 B on-time", hb, VEC[v].hb);
         chk_eq("R6 low-side inverse", mism, 0);
         @(negedge clk);
         chk_eq("R7 sync one clock", int'(sync_o), 0);
      end

      // R4: illegal periods 1 and 0 while enabled, then recovery
      wr(2'd0, 16'd0);
      wr(2'd1, 16'd1);
      wr(2'd0, 16'd3);
      quiet_count(40, q);
      chk_eq("R4 period 1 quiet", q, 0);
      wr(2'd1, 16'd0);
      quiet_count(40, q);
      chk_eq("R4 period 0 quiet", q, 0);
      wr(2'd1, 16'd6);
      wait_sync(got);
      chk_eq("R4 recovery sync", int'(got), 1);
      measure(n, ha, hb, fa, mism);
      chk_eq("R4 recovery period", n, 12);

      // R8: writes landing mid-period
      wr(2'd0, 16'd0);
      wr(2'd1, 16'd10);
      wr(2'd2, 16'd3);
      wr(2'd3, 16'd0);
      wr(2'd0, 16'd1);
      wait_sync(got);
      fork
         measure(n, ha, hb, fa, mism);
         begin
            wr(2'd1, 16'd20);
            wr(2'd2, 16'd6);
         end
      join
      chk_eq("R8 old period kept", n, 10);
      chk_eq("R8 old duty kept", ha, 3);
      measure(n, ha, hb, fa, mism);
      chk_eq("R8 new period", n, 20);
      chk_eq("R8 new duty", ha, 6);

      // R11: disable mid-run, then re-enable
      repeat (4) @(negedge clk);
      wr(2'd0, 16'd0);
      chk_eq("R11 off after write", int'({pwm_hi, pwm_lo, sync_o}), 0);
      wr(2'd0, 16'd1);
      chk_eq("R11 no sync yet", int'(sync_o), 0);
      @(negedge clk);
      chk_eq("R11 sync on restart", int'(sync_o), 1);

      // R10: 10 kHz from a 200 MHz clock, center-aligned, period value 10000
      wr(2'd0, 16'd0);
      wr(2'd1, 16'd10000);
      wr(2'd2, 16'd5000);
      wr(2'd0, 16'd3);
      wait_sync(got);
      measure(n, ha, hb, fa, mism);
      chk_eq("R10 period clocks", n, 20000);
      chk_eq("R10 frequency Hz", (n > 0) ? 200_000_000 / n : 0, 10000);
      chk_eq("R10 A on-time", ha, 10000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule